// File: doc/BRIEF.md
# PLCP Trailer Stuffing Controller

This block decides how many trailer nibbles each PLCP frame gets on a DS3 transmit path, and drives the nibble emitter that produces them. Frames are grouped into cycles of three, one every 375 us. The first frame of a cycle always carries a 13-nibble trailer and the second always carries 14. The third frame is the stuff opportunity. Its trailer is 13 or 14 nibbles, depending on an external stuff-control input.

A start-of-frame strobe moves the block to the next phase of the cycle. The stuff-control input is captured at that same strobe. A frame-end strobe starts the trailer, and the emitter then gives one nibble-valid cycle per trailer nibble. A one-cycle done pulse follows the last nibble. The block also drives the cycle code and stuffed flag that the overhead inserter needs to build its cycle/stuff indicator byte.

In clear-channel mode no PLCP trailer is generated. Both strobes and the stuff-control input are ignored, and any frame in progress is abandoned.

Top module: `plcp_stuff_ctrl`

## Requirements
- R1: After reset, phase_o is 0, trl_len_o is 13, and trl_req_o, nib_vld_o, trl_done_o, c1_code_o and c1_stuffed_o are all 0.
- R2: The first accepted sof_i after reset gives phase 0. Each later accepted sof_i moves the phase 0 to 1, 1 to 2, and 2 back to 0.
- R3: A frame in phase 0 has trl_len_o = 13. A frame in phase 1 has trl_len_o = 14.
- R4: A frame in phase 2 has trl_len_o = 13 if stuff_ctl_i was low at its sof_i, and 14 if it was high. stuff_opp_o is 1 exactly while phase_o is 2.
- R5: stuff_ctl_i is sampled only at the accepted sof_i. Changing it later, including during the trailer, does not change that frame's length.
- R6: The cycle after an accepted frame_end_i, nib_vld_o goes high. It stays high for exactly trl_len_o consecutive cycles. trl_req_o is high from the first nibble through the done pulse.
- R7: trl_done_o is a single-cycle pulse. It occurs in the cycle right after the last nibble-valid cycle.
- R8: sof_i is accepted only when idle, so a strobe during a frame or its trailer leaves phase_o unchanged. frame_end_i is accepted only after an accepted sof_i, so a strobe while idle starts no trailer.
- R9: At each trailer start, c1_code_o takes the frame's phase. c1_stuffed_o takes 1 only for a phase-2 frame stuffed to 14 nibbles. Both hold until the next trailer start.
- R10: While clear_mode_i is high, strobes and stuff_ctl_i have no effect and phase_o holds. From the cycle after clear_mode_i is seen, nib_vld_o and trl_req_o are low, which aborts any trailer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_mode_i | input | 1 | 1 = clear-channel mode, 0 = ATM UNI mode |
| stuff_ctl_i | input | 1 | External stuff control for the third frame |
| sof_i | input | 1 | Start-of-PLCP-frame strobe |
| frame_end_i | input | 1 | Frame payload complete, start trailer |
| phase_o | output | 2 | Phase of current frame within the 3-frame cycle |
| stuff_opp_o | output | 1 | Current frame is the stuff opportunity |
| trl_len_o | output | 4 | Trailer length in nibbles (13 or 14) |
| trl_req_o | output | 1 | Trailer emission in progress |
| nib_vld_o | output | 1 | One trailer nibble this cycle |
| trl_done_o | output | 1 | Pulse after last trailer nibble |
| c1_code_o | output | 2 | Cycle code for the indicator byte |
| c1_stuffed_o | output | 1 | Stuffed flag for the indicator byte |

## Verification
The assertions run on every cycle. They check that the phase stays in range and only steps forward by one, and only while idle. They check that phases 0 and 1 always carry their fixed lengths, that the length cannot move during a trailer, and that the done pulse is single and follows the last nibble. They also check that clear-channel mode silences emission and that the stuffed flag only ever accompanies code 2. What only the bench scenarios can show is the sequencing across frames. This covers the 13/14/13 and 13/14/14 patterns under held stuff control, the exact nibble count per trailer, and capture at frame start while stuff control toggles. It also covers strobes ignored mid-frame, abort on entering clear-channel mode, and the phase restarting at 0 after a second reset.

// File: rtl/plcp_stuff_pkg.sv
package plcp_stuff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_TRAIL = 2'd2
  } frm_state_e;
endpackage

// File: rtl/plcp_phase_seq.sv
module plcp_phase_seq #(
  parameter int CYC_LEN  = 3,
  parameter int PH_W     = 2,
  parameter int LONG_PH  = 1,
  parameter int STUFF_PH = 2,
  parameter int LEN_BASE = 13,
  parameter int LEN_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             stuff_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             stuffed_o,
  output logic             opp_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CYC_LEN - 1);
  localparam logic [PH_W-1:0] PH_LONG  = PH_W'(LONG_PH);
  localparam logic [PH_W-1:0] PH_STUFF = PH_W'(STUFF_PH);

  logic            started_q;
  logic            stf_q;
  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            extra;

  always_comb begin
    if (!started_q)          ph_nxt = '0;
    else if (ph_q == PH_LAST) ph_nxt = '0;
    else                      ph_nxt = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      ph_q      <= '0;
      stf_q     <= 1'b0;
    end else if (adv_i) begin
      started_q <= 1'b1;
      ph_q      <= ph_nxt;
      // stuff decision frozen for the whole frame
      stf_q     <= (ph_nxt == PH_STUFF) && stuff_i;
    end
  end

  assign extra     = (ph_q == PH_LONG) || stf_q;
  assign len_o     = LEN_W'(LEN_BASE) + {{(LEN_W-1){1'b0}}, extra};
  assign phase_o   = ph_q;
  assign stuffed_o = stf_q;
  assign opp_o     = (ph_q == PH_STUFF);
endmodule

// File: rtl/plcp_nib_emitter.sv
module plcp_nib_emitter #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             vld_o,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == LEN_W'(1));
      if (start_i)              cnt_q <= len_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign vld_o  = (cnt_q != '0);
  assign done_o = done_q;
endmodule

// File: rtl/plcp_frame_fsm.sv
module plcp_frame_fsm
  import plcp_stuff_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sof_i,
  input  logic fend_i,
  input  logic emit_done_i,
  output logic adv_o,
  output logic start_o,
  output logic req_o
);
  frm_state_e st_q, st_d;

  assign adv_o   = !clear_i && sof_i  && (st_q == ST_IDLE);
  assign start_o = !clear_i && fend_i && (st_q == ST_FRAME);
  assign req_o   = (st_q == ST_TRAIL);

  always_comb begin
    st_d = st_q;
    if (clear_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (sof_i)       st_d = ST_FRAME;
        ST_FRAME: if (fend_i)      st_d = ST_TRAIL;
        ST_TRAIL: if (emit_done_i) st_d = ST_IDLE;
        default:                   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/plcp_stuff_ctrl.sv
module plcp_stuff_ctrl #(
  parameter int CYC_LEN  = 3,
  parameter int LONG_PH  = 1,
  parameter int LEN_BASE = 13,
  parameter int LEN_W    = 4,
  localparam int PH_W     = $clog2(CYC_LEN),
  localparam int STUFF_PH = CYC_LEN - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_mode_i,
  input  logic             stuff_ctl_i,
  input  logic             sof_i,
  input  logic             frame_end_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             stuff_opp_o,
  output logic [LEN_W-1:0] trl_len_o,
  output logic             trl_req_o,
  output logic             nib_vld_o,
  output logic             trl_done_o,
  output logic [PH_W-1:0]  c1_code_o,
  output logic             c1_stuffed_o
);
  logic adv, start, emit_done, stuffed;
  logic [PH_W-1:0] c1_code_q;
  logic            c1_stf_q;

  plcp_frame_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_mode_i),
    .sof_i       (sof_i),
    .fend_i      (frame_end_i),
    .emit_done_i (emit_done),
    .adv_o       (adv),
    .start_o     (start),
    .req_o       (trl_req_o)
  );

  plcp_phase_seq #(
    .CYC_LEN (CYC_LEN), .PH_W (PH_W), .LONG_PH (LONG_PH),
    .STUFF_PH(STUFF_PH), .LEN_BASE(LEN_BASE), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .stuff_i   (stuff_ctl_i),
    .phase_o   (phase_o),
    .stuffed_o (stuffed),
    .opp_o     (stuff_opp_o),
    .len_o     (trl_len_o)
  );

  plcp_nib_emitter #(.LEN_W(LEN_W)) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (clear_mode_i),
    .start_i (start),
    .len_i   (trl_len_o),
    .vld_o   (nib_vld_o),
    .done_o  (emit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_code_q <= '0;
      c1_stf_q  <= 1'b0;
    end else if (start) begin
      c1_code_q <= phase_o;
      c1_stf_q  <= stuffed;
    end
  end

  assign trl_done_o   = emit_done;
  assign c1_code_o    = c1_code_q;
  assign c1_stuffed_o = c1_stf_q;
endmodule

// File: rtl/plcp_stuff_ctrl_chk.sv
module plcp_stuff_ctrl_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_mode_i,
  input logic [1:0]       phase_o,
  input logic [LEN_W-1:0] trl_len_o,
  input logic             trl_req_o,
  input logic             nib_vld_o,
  input logic             trl_done_o,
  input logic [1:0]       c1_code_o,
  input logic             c1_stuffed_o
);
  localparam logic [LEN_W-1:0] L_SHORT = LEN_W'(13);
  localparam logic [LEN_W-1:0] L_LONG  = LEN_W'(14);

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3); // R2
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |->
      (phase_o == (($past(phase_o) == 2'd2) ? 2'd0 : $past(phase_o) + 2'd1))); // R2
  AST_PHASE_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> (!$past(trl_req_o) && !$past(nib_vld_o))); // R8
  AST_FIXED_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 2'd2) |-> (trl_len_o == ((phase_o == 2'd1) ? L_LONG : L_SHORT))); // R3
  AST_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trl_len_o == L_SHORT) || (trl_len_o == L_LONG)); // R4
  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_o |-> $stable(trl_len_o)); // R5
  AST_REQ_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_o |-> trl_req_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trl_done_o |=> !trl_done_o); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trl_done_o |-> (!nib_vld_o && $past(nib_vld_o))); // R7
  AST_C1_STUFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c1_stuffed_o |-> (c1_code_o == 2'd2)); // R9
  AST_CLEAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_mode_i |=> (!nib_vld_o && !trl_req_o)); // R10
endmodule

bind plcp_stuff_ctrl plcp_stuff_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_mode_i (clear_mode_i),
  .phase_o      (phase_o),
  .trl_len_o    (trl_len_o),
  .trl_req_o    (trl_req_o),
  .nib_vld_o    (nib_vld_o),
  .trl_done_o   (trl_done_o),
  .c1_code_o    (c1_code_o),
  .c1_stuffed_o (c1_stuffed_o)
);

// File: tb/sim_plcp_stuff_ctrl.sv
`timescale 1ns/1ps
module sim_plcp_stuff_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_mode, stuff_ctl, sof, fend;
  logic [1:0] phase, c1_code;
  logic [3:0] len;
  logic opp, req, vld, done, c1_stf;

  int n_chk = 0, n_fail = 0;
  int eph = 0;
  bit started = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  plcp_stuff_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_mode_i(clear_mode),
    .stuff_ctl_i(stuff_ctl), .sof_i(sof), .frame_end_i(fend),
    .phase_o(phase), .stuff_opp_o(opp), .trl_len_o(len),
    .trl_req_o(req), .nib_vld_o(vld), .trl_done_o(done),
    .c1_code_o(c1_code), .c1_stuffed_o(c1_stf)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clear_mode = 0; stuff_ctl = 0; sof = 0; fend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    started = 0; eph = 0;
    chk("R1 phase", phase, 0);
    chk("R1 len", len, 13);
    chk("R1 req", req, 0);
    chk("R1 vld", vld, 0);
    chk("R1 done", done, 0);
    chk("R1 c1", {c1_code, c1_stf}, 0);
  endtask

  // one frame: stuff level at sof, level after, toggle during trailer, poke sof mid-trailer
  task automatic do_frame(input bit stf, input bit stf_after, input bit toggle, input bit poke);
    int exp_len, cnt;
    bit seen_done;
    if (!started) eph = 0; else eph = (eph + 1) % 3;
    started = 1;
    exp_len = 13 + (((eph == 1) || (eph == 2 && stf)) ? 1 : 0);
    @(negedge clk); stuff_ctl = stf; sof = 1;
    @(negedge clk); sof = 0; stuff_ctl = stf_after;
    chk("R2 phase", phase, eph);
    chk((eph == 2) ? "R4 len" : "R3 len", len, exp_len);
    chk("R4 opp", opp, (eph == 2) ? 1 : 0);
    @(negedge clk); fend = 1;
    @(negedge clk); fend = 0;
    chk("R6 req", req, 1);
    cnt = 0; seen_done = 0;
    for (int k = 0; k < 40; k++) begin
      if (vld) cnt++;
      if (done) begin
        seen_done = 1;
        chk("R7 done after last", vld, 0);
        chk("R6 req through done", req, 1);
        break;
      end
      if (toggle) stuff_ctl = ~stuff_ctl;
      sof = poke && (k == 2);
      @(negedge clk);
    end
    sof = 0;
    chk("R7 done seen", seen_done, 1);
    chk("R5/R6 nibble count", cnt, exp_len);
    chk("R5 len held", len, exp_len);
    chk("R9 c1 code", c1_code, eph);
    chk("R9 c1 stuffed", c1_stf, (eph == 2 && stf) ? 1 : 0);
    if (poke) chk("R8 sof in trailer", phase, eph);
    @(negedge clk);
    chk("R7 done single", done, 0);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R3/R4 stuff low: 13/14/13
    for (int i = 0; i < 6; i++) do_frame(0, 0, 0, 0);
    // stuff high: 13/14/14
    for (int i = 0; i < 6; i++) do_frame(1, 1, 0, 0);
    // R5 toggling after capture and during trailer
    for (int i = 0; i < 3; i++) do_frame(1, 0, 1, 0);
    for (int i = 0; i < 3; i++) do_frame(0, 1, 1, 0);
    // R8 sof during trailer
    for (int i = 0; i < 3; i++) do_frame(i[0], 0, 0, 1);
    // R8 frame_end while idle
    @(negedge clk); fend = 1;
    @(negedge clk); fend = 0;
    chk("R8 fend idle vld", vld, 0);
    chk("R8 fend idle req", req, 0);
    @(negedge clk);
    chk("R8 fend idle vld2", vld, 0);
    // R8 sof during frame (before frame_end)
    eph = (eph + 1) % 3;
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    chk("R2 phase", phase, eph);
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    chk("R8 sof in frame", phase, eph);
    // R10 abort mid-trailer
    @(negedge clk); fend = 1;
    @(negedge clk); fend = 0;
    repeat (3) @(negedge clk);
    chk("R10 trailer running", vld, 1);
    clear_mode = 1;
    @(negedge clk);
    chk("R10 abort vld", vld, 0);
    chk("R10 abort req", req, 0);
    // R10 strobes ignored in clear mode
    stuff_ctl = 1; sof = 1;
    @(negedge clk); sof = 0; fend = 1;
    @(negedge clk); fend = 0;
    @(negedge clk);
    chk("R10 phase hold", phase, eph);
    chk("R10 vld", vld, 0);
    chk("R10 req", req, 0);
    chk("R10 done", done, 0);
    clear_mode = 0; stuff_ctl = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) do_frame(1, 1, 0, 0);
    // R1/R2 second reset restarts at phase 0
    do_reset();
    for (int i = 0; i < 3; i++) do_frame(1, 1, 1, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule